// File: doc/BRIEF.md
# Block-Transfer Sequencer

This block carries out one block-transfer operation at a time: every register whose bit is set in a 16-bit list is moved between the register file and memory, one 32-bit word per cycle. Addressing starts from a base value. A store runs in descending-stack (push) form: the address is lowered first, then the words are written. A load runs in ascending (pop) form: the words are read first, then the address is raised.

In either direction the lowest-numbered register uses the lowest address. If the caller asks for it, the final base value is offered for writeback. When a load includes register 15, the block signals a branch, because the word loaded into that register is the new program counter.

The memory is assumed to complete an access in the same cycle: read data is valid in the cycle that the read strobe is high. The register file is read combinationally at the index the block presents. It is written on the clock edge that ends a cycle in which the write strobe is high.

Top module: `blk_xfer_seq`

## Requirements
- R1: Each register whose bit is set in `regList` is transferred exactly once, in ascending register-number order, one register per cycle. The index appears on `rfIdx`.
- R2: A store (`isLoad`=0) starts at `baseIn - 4*N`, where N is the number of set bits. In each beat it asserts `memWr` and `rfRdStb`, and `memWdata` equals `rfRdata`.
- R3: A load (`isLoad`=1) starts at `baseIn`. In each beat it asserts `memRd` and `rfWrStb`, and `rfWdata` equals `memRdata`.
- R4: The memory address rises by 4 from one beat to the next, so the lowest register gets the lowest address.
- R5: In the done cycle, `baseWrStb` equals the latched writeback flag. `baseOut` then equals `baseIn - 4*N` for a store and `baseIn + 4*N` for a load.
- R6: `branch` pulses in the done cycle only when a load's list has bit 15 set. A store that includes register 15 never raises `branch`.
- R7: An empty list gives `done` in the cycle after the start. It makes no memory access, and `baseOut` equals `baseIn`.
- R8: `busy` is high from the cycle after an accepted start through the done cycle. A `start` pulse that arrives while `busy` is high is ignored.
- R9: `done` is high for exactly one cycle, immediately after the last beat.
- R10: After reset, `busy`, `done`, `memRd`, `memWr` and `rfWrStb` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, sampled only while idle |
| isLoad | input | 1 | 1 = load increment-after, 0 = store decrement-before |
| wrBack | input | 1 | Request base writeback |
| baseIn | input | 32 | Base address |
| regList | input | 16 | Register list, bit i selects register i |
| memAddr | output | 32 | Memory word address |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, same cycle |
| rfIdx | output | 4 | Register-file index |
| rfRdStb | output | 1 | Register-file read strobe |
| rfWrStb | output | 1 | Register-file write strobe |
| rfWdata | output | 32 | Register-file write data |
| rfRdata | input | 32 | Register-file read data |
| baseOut | output | 32 | Final base value |
| baseWrStb | output | 1 | Base writeback strobe |
| branch | output | 1 | Register 15 was loaded |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle: a read and a write never occur in the same beat, `done` never lasts two cycles, and `branch` appears only together with `done`. They also check that the address steps by 4 between beats, that a start arriving mid-transfer does not disturb the remaining list, and that an empty list completes at once. The bench scenarios cover the rest. They check the actual start addresses for both directions, the ascending register order and the data path against a memory model. They check the final base value, and that a pop restores the values an earlier push saved. Last, they cover the branch for a load that includes register 15, and its absence for a store that includes it.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_DONE} seqState_e;

  typedef struct packed {
    logic capture;
    logic step;
  } dpCtrl_t;
endpackage

// File: rtl/blk_xfer_ctrl.sv
module blk_xfer_ctrl
  import blk_xfer_pkg::*;
#(
  parameter int NREGS = 16,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             isLoad,
  input  logic             wrBack,
  input  logic [NREGS-1:0] regList,
  output dpCtrl_t          dpCtrl,
  output logic             memRd,
  output logic             memWr,
  output logic [IDX_W-1:0] rfIdx,
  output logic             rfRdStb,
  output logic             rfWrStb,
  output logic             baseWrStb,
  output logic             branch,
  output logic             busy,
  output logic             done
);
  seqState_e        state;
  logic [NREGS-1:0] remList;
  logic             opLoad, opWb, pcHit;
  logic             inXfer, lastBeat, accept;
  logic [IDX_W-1:0] curIdx;

  assign accept   = start && (state == ST_IDLE);
  assign inXfer   = (state == ST_XFER);
  assign lastBeat = ((remList & (remList - 1'b1)) == '0);

  always_comb begin
    curIdx = '0;
    for (int i = NREGS - 1; i >= 0; i--) begin
      if (remList[i]) curIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      remList <= '0;
      opLoad  <= 1'b0;
      opWb    <= 1'b0;
      pcHit   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          remList <= regList;
          opLoad  <= isLoad;
          opWb    <= wrBack;
          pcHit   <= isLoad && regList[NREGS-1];
          state   <= (regList == '0) ? ST_DONE : ST_XFER;
        end
        ST_XFER: begin
          remList <= remList & (remList - 1'b1);
          if (lastBeat) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dpCtrl.capture = accept;
  assign dpCtrl.step    = inXfer;
  assign memRd     = inXfer && opLoad;
  assign memWr     = inXfer && !opLoad;
  assign rfRdStb   = memWr;
  assign rfWrStb   = memRd;
  assign rfIdx     = curIdx;
  assign done      = (state == ST_DONE);
  assign baseWrStb = done && opWb;
  assign branch    = done && pcHit;
  assign busy      = (state != ST_IDLE);

  p_rd_wr_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_branch_in_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    branch |-> (done && memRd == 1'b0));
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inXfer && start) |=> (remList == ($past(remList) & ($past(remList) - 1'b1))));
  p_empty_list_r7: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && regList == '0) |=> (done && !memRd && !memWr));
endmodule

// File: rtl/blk_xfer_dpath.sv
module blk_xfer_dpath
  import blk_xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREGS      = 16,
  parameter int WORD_BYTES = 4,
  localparam int CNT_W     = $clog2(NREGS + 1),
  localparam int SHIFT     = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic              isLoad,
  input  logic [ADDR_W-1:0] baseIn,
  input  logic [NREGS-1:0]  regList,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] baseOut
);
  logic [CNT_W-1:0]  popCnt;
  logic [ADDR_W-1:0] span, curAddr, finalBase;

  assign popCnt = CNT_W'($countones(regList));
  assign span   = ADDR_W'(popCnt) << SHIFT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      finalBase <= '0;
    end else if (dpCtrl.capture) begin
      curAddr   <= isLoad ? baseIn : baseIn - span;
      finalBase <= isLoad ? baseIn + span : baseIn - span;
    end else if (dpCtrl.step) begin
      curAddr   <= curAddr + ADDR_W'(WORD_BYTES);
    end
  end

  assign memAddr = curAddr;
  assign baseOut = finalBase;

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtrl.step && !dpCtrl.capture) |=> (memAddr == $past(memAddr) + ADDR_W'(WORD_BYTES)));
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NREGS  = 16,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isLoad,
  input  logic              wrBack,
  input  logic [ADDR_W-1:0] baseIn,
  input  logic [NREGS-1:0]  regList,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [IDX_W-1:0]  rfIdx,
  output logic              rfRdStb,
  output logic              rfWrStb,
  output logic [DATA_W-1:0] rfWdata,
  input  logic [DATA_W-1:0] rfRdata,
  output logic [ADDR_W-1:0] baseOut,
  output logic              baseWrStb,
  output logic              branch,
  output logic              busy,
  output logic              done
);
  dpCtrl_t dpCtrl;

  blk_xfer_ctrl #(.NREGS(NREGS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .isLoad(isLoad), .wrBack(wrBack),
    .regList(regList), .dpCtrl(dpCtrl), .memRd(memRd), .memWr(memWr),
    .rfIdx(rfIdx), .rfRdStb(rfRdStb), .rfWrStb(rfWrStb),
    .baseWrStb(baseWrStb), .branch(branch), .busy(busy), .done(done)
  );

  blk_xfer_dpath #(.ADDR_W(ADDR_W), .NREGS(NREGS)) u_dpath (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .isLoad(isLoad),
    .baseIn(baseIn), .regList(regList), .memAddr(memAddr), .baseOut(baseOut)
  );

  assign memWdata = rfRdata;
  assign rfWdata  = memRdata;
endmodule

// File: tb/test_blk_xfer_seq.sv
module test_blk_xfer_seq;
  logic        clk = 1'b0, rstN = 1'b0, start = 1'b0, isLoad = 1'b0, wrBack = 1'b0;
  logic [31:0] baseIn = '0;
  logic [15:0] regList = '0;
  logic [31:0] memAddr, memWdata, memRdata, rfWdata, rfRdata, baseOut;
  logic        memRd, memWr, rfRdStb, rfWrStb, baseWrStb, branch, busy, done;
  logic [3:0]  rfIdx;
  logic [31:0] mem [64];
  logic [31:0] rf [16];
  int checks = 0, failures = 0;

  always #10ns clk = ~clk;

  blk_xfer_seq i_blk_xfer_seq (
    .clk(clk), .rstN(rstN), .start(start), .isLoad(isLoad), .wrBack(wrBack),
    .baseIn(baseIn), .regList(regList), .memAddr(memAddr), .memRd(memRd),
    .memWr(memWr), .memWdata(memWdata), .memRdata(memRdata), .rfIdx(rfIdx),
    .rfRdStb(rfRdStb), .rfWrStb(rfWrStb), .rfWdata(rfWdata), .rfRdata(rfRdata),
    .baseOut(baseOut), .baseWrStb(baseWrStb), .branch(branch), .busy(busy), .done(done)
  );

  assign memRdata = mem[memAddr[7:2]];
  assign rfRdata  = rf[rfIdx];

  always @(posedge clk) begin
    if (memWr) mem[memAddr[7:2]] <= memWdata;
    if (rfWrStb) rf[rfIdx] <= rfWdata;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input bit ld, input bit wb, input logic [31:0] base,
                     input logic [15:0] list, input bit poke, output logic [31:0] newBase);
    int n = 0;
    int k = 0;
    logic [31:0] first, fin;
    for (int i = 0; i < 16; i++) if (list[i]) n++;
    first = ld ? base : base - 32'(4 * n);
    fin   = ld ? base + 32'(4 * n) : base - 32'(4 * n);
    @(negedge clk);
    isLoad = ld; wrBack = wb; baseIn = base; regList = list; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (list[i]) begin
        check(busy, "R8 busy in beat", 32'(busy), 32'd1);
        check(memAddr == first + 32'(4 * k), "R4 beat address", memAddr, first + 32'(4 * k));
        check(rfIdx == 4'(i), "R1 register order", 32'(rfIdx), 32'(i));
        check(!done, "R9 no done mid-transfer", 32'(done), 32'd0);
        if (ld) begin
          check(memRd && rfWrStb && !memWr, "R3 load strobes", {29'd0, memRd, rfWrStb, memWr}, 32'd6);
          check(rfWdata == mem[memAddr[7:2]], "R3 load data", rfWdata, mem[memAddr[7:2]]);
        end else begin
          check(memWr && rfRdStb && !memRd, "R2 store strobes", {29'd0, memWr, rfRdStb, memRd}, 32'd6);
          check(memWdata == rf[i], "R2 store data", memWdata, rf[i]);
        end
        if (poke && k == 0) begin
          start = 1'b1; regList = 16'hFFFF;
        end else begin
          start = 1'b0; regList = list;
        end
        k++;
        @(negedge clk);
      end
    end
    start = 1'b0;
    check(done && busy, "R9 done after last beat", {30'd0, done, busy}, 32'd3);
    check(!memRd && !memWr, "R7 no access in done cycle", {30'd0, memRd, memWr}, 32'd0);
    check(baseWrStb == wb, "R5 writeback strobe", 32'(baseWrStb), 32'(wb));
    if (wb) check(baseOut == fin, "R5 final base", baseOut, fin);
    check(branch == (ld && list[15]), "R6 branch", 32'(branch), 32'(ld && list[15]));
    newBase = baseOut;
    @(negedge clk);
    check(!done && !busy, "R9 done one cycle, R8 idle after", {30'd0, done, busy}, 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!busy && !done && !memRd && !memWr && !rfWrStb, "R10 reset state",
          {27'd0, busy, done, memRd, memWr, rfWrStb}, 32'd0);
    rstN = 1'b1;
  endtask

  task automatic t_push_pop();
    logic [31:0] nb, nb2;
    rf[0] = 32'd10; rf[1] = 32'd50; rf[2] = 32'd100;
    run(1'b0, 1'b1, 32'h100, 16'h0007, 1'b0, nb);
    check(nb == 32'hF4, "R2 push base", nb, 32'hF4);
    check(mem[61] == 32'd10 && mem[63] == 32'd100, "R2 lowest reg lowest address", mem[61], 32'd10);
    rf[0] = 0; rf[1] = 0; rf[2] = 0;
    run(1'b1, 1'b1, nb, 16'h0007, 1'b0, nb2);
    check(nb2 == 32'h100, "R3 pop base restored", nb2, 32'h100);
    check(rf[0] == 32'd10 && rf[1] == 32'd50 && rf[2] == 32'd100, "R3 registers restored", rf[1], 32'd50);
  endtask

  task automatic t_pop_pc();
    logic [31:0] nb;
    mem[16] = 32'hA; mem[17] = 32'hB; mem[18] = 32'h2000;
    run(1'b1, 1'b1, 32'h40, 16'h8003, 1'b0, nb);
    check(rf[15] == 32'h2000, "R6 pc loaded", rf[15], 32'h2000);
  endtask

  task automatic t_store_pc();
    logic [31:0] nb;
    rf[15] = 32'h5555; rf[4] = 32'h44;
    run(1'b0, 1'b0, 32'hC0, 16'h8010, 1'b0, nb);
    check(mem[47] == 32'h5555 && mem[46] == 32'h44, "R2 store with r15", mem[47], 32'h5555);
  endtask

  task automatic t_empty();
    @(negedge clk);
    isLoad = 1'b0; wrBack = 1'b1; baseIn = 32'h80; regList = 16'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done && !memRd && !memWr, "R7 empty list done", {29'd0, done, memRd, memWr}, 32'd4);
    check(baseOut == 32'h80, "R7 base unchanged", baseOut, 32'h80);
    @(negedge clk);
    check(!done && !busy, "R7 empty idle after", {30'd0, done, busy}, 32'd0);
  endtask

  task automatic t_full();
    logic [31:0] nb;
    for (int i = 0; i < 16; i++) rf[i] = 32'h100 + 32'(i);
    run(1'b0, 1'b1, 32'h80, 16'hFFFF, 1'b0, nb);
    check(mem[16] == 32'h100 && mem[31] == 32'h10F, "R1 full list stored", mem[31], 32'h10F);
  endtask

  task automatic t_sparse_nowb();
    logic [31:0] nb;
    run(1'b1, 1'b0, 32'h40, 16'h0421, 1'b0, nb);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] nb;
    run(1'b1, 1'b1, 32'h40, 16'h0030, 1'b1, nb);
    check(nb == 32'h48, "R8 start while busy ignored", nb, 32'h48);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD0000 + 32'(i);
    for (int i = 0; i < 16; i++) rf[i] = 32'h0;
    t_reset();
    t_push_pop();
    t_pop_pc();
    t_store_pc();
    t_empty();
    t_full();
    t_sparse_nowb();
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2ms;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule